// File: doc/BRIEF.md
# Word-Register Serial Port Front End

This block is the register side of a byte-oriented serial port. A processor reaches it through a simple 32-bit word bus with one access per cycle. Behind the registers sit two small FIFOs. Bytes that software writes queue up for an outgoing byte stream. Bytes that arrive on an incoming byte stream queue up until software reads them. Each direction moves data only while its own enable bit is set. The bit timing on the wire, the baud divider and interrupts live elsewhere. The divisor, interrupt-enable and interrupt-pending words are kept only as fixed placeholders.

A read returns its data and response code in the same cycle as the request. Side effects take place at the clock edge that ends the access: a push, a pop or a change to an enable bit. The response code is 0 for success and 1 for an offset inside the 28-byte window that is not a multiple of four. It is 2 for any offset at 0x1C or above. A failed access has no side effect and reads as zero. In the data words, bit 31 flags a full transmit queue or an empty receive queue.

Top module: `serial_reg_front`

## Requirements
- R1: After reset both enables are clear and both queues are empty, so `txValid` and `rxReady` are low, offset 0x08 reads 0 and offset 0x04 reads 0x80000000.
- R2: A write to offset 0x00 queues bits 7:0 of the write data. Queued bytes leave on the transmit stream in the order they were written, one per cycle in which `txValid` and `txReady` are both high.
- R3: A read of offset 0x00 returns 0x80000000 while the transmit queue is full and 0 otherwise. A write to offset 0x00 while the queue is full is dropped without any effect.
- R4: A read of offset 0x04 removes the oldest received byte and returns it in bits 7:0 with bits 31:8 zero. When the receive queue is empty it returns 0x80000000 and removes nothing.
- R5: Bit 0 of a write to offset 0x08 sets the transmit enable and bit 0 of a write to offset 0x0C sets the receive enable. A read of either offset returns the enable as 0 or 1.
- R6: `txValid` is high only while transmit is enabled and the transmit queue holds a byte. `txData` shows the oldest queued byte and stays unchanged while it waits for `txReady`.
- R7: `rxReady` is high only while receive is enabled and the receive queue is not full. A byte is taken from the stream only in a cycle where `rxValid` and `rxReady` are both high.
- R8: Writes to offsets 0x04, 0x10, 0x14 and 0x18 change nothing. Offsets 0x10 and 0x14 read 0 and offset 0x18 reads 1.
- R9: An offset below 0x1C whose low two bits are not zero answers with code 1, reads 0 and has no side effect.
- R10: An offset of 0x1C or more answers with code 2, reads 0 and has no side effect.
- R11: Each queue holds exactly `DEPTH` bytes (8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Bus access in this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqWdata | input | 32 | Write data |
| rspRdata | output | 32 | Read data, valid in the request cycle |
| rspErr | output | 2 | 0 success, 1 misaligned, 2 outside the window |
| txValid | output | 1 | Outgoing byte available |
| txData | output | 8 | Outgoing byte |
| txReady | input | 1 | Downstream takes the outgoing byte |
| rxValid | input | 1 | Incoming byte offered |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | Block takes the incoming byte |

## Verification
The hardest states to reach from the ports are a full transmit queue and a ninth write that must be dropped, because the queue drains as soon as transmit is enabled and the downstream is ready. The stimulus first turns transmit off and holds `txReady` low. It then writes nine bytes, so the extra byte would show up on the stream as an item the scoreboard never expected. The full receive queue is reached the same way: the bench offers bytes with software reads held back until `rxReady` falls.

// File: rtl/serial_front_pkg.sv
package serial_front_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WINDOW_END = 28;

  typedef enum logic [1:0] {
    RESP_OK       = 2'd0,
    RESP_MISALIGN = 2'd1,
    RESP_FAULT    = 2'd2
  } respCode_e;

  typedef enum logic [2:0] {
    SEL_TXDATA,
    SEL_RXDATA,
    SEL_TXCTRL,
    SEL_RXCTRL,
    SEL_ZERO,
    SEL_ONE
  } readSel_e;

  typedef struct packed {
    logic     txPush;
    logic     rxPop;
    logic     txEnable;
    logic     rxEnable;
    readSel_e readSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/serial_front_fifo.sv
module serial_front_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReq,
  output logic [WIDTH-1:0] headData,
  output logic             isFull,
  output logic             isEmpty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] fillCount;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign isFull   = (fillCount == CNT_W'(DEPTH));
  assign isEmpty  = (fillCount == '0);
  assign doPush   = pushReq && !isFull;
  assign doPop    = popReq && !isEmpty;
  assign headData = store[tailPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      fillCount <= '0;
    end else begin
      if (doPush) headPtr <= stepPtr(headPtr);
      if (doPop)  tailPtr <= stepPtr(tailPtr);
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + CNT_W'(1);
        2'b01:   fillCount <= fillCount - CNT_W'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[headPtr] <= pushData;
  end

  // R11: a push into a full queue without a pop leaves it full
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && pushReq && !popReq) |=> isFull);

  // R11: occupancy moves by at most one per cycle
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount != $past(fillCount)) |->
      (fillCount == $past(fillCount) + CNT_W'(1) ||
       fillCount == $past(fillCount) - CNT_W'(1)));

endmodule

// File: rtl/serial_front_ctrl.sv
module serial_front_ctrl
  import serial_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              ctrlBit,
  output ctrlStrobes_t      strobes,
  output respCode_e         rspErr
);

  logic       txEnQ, rxEnQ;
  logic       inWindow, aligned, hit;
  logic [2:0] regIdx;
  readSel_e   decodedSel;

  assign inWindow = (reqAddr < ADDR_W'(WINDOW_END));
  assign aligned  = (reqAddr[1:0] == 2'b00);
  assign regIdx   = reqAddr[4:2];

  always_comb begin
    if (!inWindow)     rspErr = RESP_FAULT;
    else if (!aligned) rspErr = RESP_MISALIGN;
    else               rspErr = RESP_OK;
  end

  assign hit = reqValid && (rspErr == RESP_OK);

  always_comb begin
    case (regIdx)
      3'd0:    decodedSel = SEL_TXDATA;
      3'd1:    decodedSel = SEL_RXDATA;
      3'd2:    decodedSel = SEL_TXCTRL;
      3'd3:    decodedSel = SEL_RXCTRL;
      3'd6:    decodedSel = SEL_ONE;
      default: decodedSel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ <= 1'b0;
      rxEnQ <= 1'b0;
    end else if (hit && reqWrite) begin
      if (regIdx == 3'd2) txEnQ <= ctrlBit;
      if (regIdx == 3'd3) rxEnQ <= ctrlBit;
    end
  end

  always_comb begin
    strobes.txPush   = hit && reqWrite && (regIdx == 3'd0);
    strobes.rxPop    = hit && !reqWrite && (regIdx == 3'd1);
    strobes.txEnable = txEnQ;
    strobes.rxEnable = rxEnQ;
    strobes.readSel  = (rspErr == RESP_OK) ? decodedSel : SEL_ZERO;
  end

  // R5: a good write to the transmit control word loads its bit 0
  assert_tx_enable_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == ADDR_W'(8)) |=> (txEnQ == $past(ctrlBit)));

  // R9 / R10: a rejected access never moves data
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspErr != RESP_OK) |-> (!strobes.txPush && !strobes.rxPop));

endmodule

// File: rtl/serial_front_datapath.sv
module serial_front_datapath
  import serial_front_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [WORD_W-1:0] rspRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady
);

  localparam logic [WORD_W-1:0] FLAG_WORD = WORD_W'(1) << (WORD_W - 1);

  logic              txFull, txEmpty, rxFull, rxEmpty;
  logic [BYTE_W-1:0] rxHead;

  assign txValid = strobes.txEnable && !txEmpty;
  assign rxReady = strobes.rxEnable && !rxFull;

  serial_front_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) txQueue (
    .clk      (clk),
    .rstN     (rstN),
    .pushReq  (strobes.txPush),
    .pushData (wrByte),
    .popReq   (txValid && txReady),
    .headData (txData),
    .isFull   (txFull),
    .isEmpty  (txEmpty)
  );

  serial_front_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) rxQueue (
    .clk      (clk),
    .rstN     (rstN),
    .pushReq  (rxValid && rxReady),
    .pushData (rxData),
    .popReq   (strobes.rxPop),
    .headData (rxHead),
    .isFull   (rxFull),
    .isEmpty  (rxEmpty)
  );

  always_comb begin
    case (strobes.readSel)
      SEL_TXDATA: rspRdata = txFull ? FLAG_WORD : '0;
      SEL_RXDATA: rspRdata = rxEmpty ? FLAG_WORD : WORD_W'(rxHead);
      SEL_TXCTRL: rspRdata = WORD_W'(strobes.txEnable);
      SEL_RXCTRL: rspRdata = WORD_W'(strobes.rxEnable);
      SEL_ONE:    rspRdata = WORD_W'(1);
      default:    rspRdata = '0;
    endcase
  end

  // R6: outgoing byte offered only while transmit is enabled
  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> strobes.txEnable);

  // R6: a waiting outgoing byte holds still
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData));

  // R7: incoming bytes accepted only while receive is enabled
  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> strobes.rxEnable);

  // R4: popping an empty receive queue reports the empty flag
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxPop && rxEmpty) |-> (rspRdata == FLAG_WORD));

endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rspRdata,
  output logic [1:0]        rspErr,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady
);

  ctrlStrobes_t strobes;
  respCode_e    respCode;
  logic         unusedWdataBits;

  assign unusedWdataBits = ^reqWdata[31:8];
  assign rspErr          = respCode;

  serial_front_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .ctrlBit  (reqWdata[0]),
    .strobes  (strobes),
    .rspErr   (respCode)
  );

  serial_front_datapath #(.DEPTH(DEPTH)) datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrByte   (reqWdata[7:0]),
    .rspRdata (rspRdata),
    .txValid  (txValid),
    .txData   (txData),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .rxReady  (rxReady)
  );

endmodule

// File: tb/serial_reg_front_test.sv
module serial_reg_front_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rspRdata;
  logic [1:0]  rspErr;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;

  int checks = 0;
  int errors = 0;
  logic [7:0] txExpect[$];

  always #2 clk = ~clk;

  serial_reg_front uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata), .rspErr(rspErr),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady)
  );

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, actual, expected);
    end
  endtask

  // one bus access; samples response mid-cycle, side effects at the next rising edge
  task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] wdata,
                        output logic [31:0] rdata, output logic [1:0] err);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    #1;
    rdata = rspRdata; err = rspErr;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, input string req, input logic [31:0] exp);
    logic [31:0] d; logic [1:0] e;
    access(1'b0, addr, 32'h0, d, e);
    check(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] d; logic [1:0] e;
    access(1'b1, addr, data, d, e);
  endtask

  // driver: software write to the transmit word plus scoreboard entry
  task automatic sendByte(input logic [7:0] b, input bit willFit);
    wr(8'h00, {24'hABCDEF, b});
    if (willFit) txExpect.push_back(b);
  endtask

  task automatic rxOffer(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    #1;
    check("R7 rxReady while room", {31'b0, rxReady}, 32'd1);
    @(posedge clk);
    #1;
    rxValid = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each transmit handshake against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rstN && txValid && txReady) begin
      checks++;
      if (txExpect.size() == 0) begin
        errors++;
        $display("FAIL R2 actual=0x%02h expected=no byte", txData);
      end else begin
        logic [7:0] exp;
        exp = txExpect.pop_front();
        if (txData !== exp) begin
          errors++;
          $display("FAIL R2 actual=0x%02h expected=0x%02h", txData, exp);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [1:0] e;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    #1;
    // R1 reset state
    check("R1 txValid", {31'b0, txValid}, 0);
    check("R1 rxReady", {31'b0, rxReady}, 0);
    rd(8'h08, "R1 R5 tx enable", 0);
    rd(8'h0C, "R1 R5 rx enable", 0);
    rd(8'h04, "R1 R4 empty rx", 32'h8000_0000);

    // R6: queued byte waits while disabled
    txReady = 1'b1;
    sendByte(8'hA5, 1);
    waitCycles(3); #1;
    check("R6 no valid while disabled", {31'b0, txValid}, 0);
    wr(8'h08, 32'hFFFF_FFF1);
    rd(8'h08, "R5 tx enable reads 1", 1);
    waitCycles(4);
    check("R2 drained", txExpect.size(), 0);

    // R3 R11: fill the transmit queue with drain held off
    wr(8'h08, 32'h0);
    txReady = 1'b0;
    for (int i = 0; i < 8; i++) sendByte(8'h30 + 8'(i), 1);
    rd(8'h00, "R3 full flag", 32'h8000_0000);
    sendByte(8'hEE, 0);
    wr(8'h08, 32'h1);
    #1;
    check("R6 valid when enabled", {31'b0, txValid}, 1);
    check("R6 head byte", {24'b0, txData}, 32'h30);
    waitCycles(3); #1;
    check("R6 head held", {24'b0, txData}, 32'h30);
    @(negedge clk); txReady = 1'b1;
    waitCycles(14); #1;
    check("R2 R3 all drained", txExpect.size(), 0);
    check("R6 idle after drain", {31'b0, txValid}, 0);
    rd(8'h00, "R3 not full", 0);

    // R7 R11: receive path
    @(negedge clk); rxValid = 1'b1; rxData = 8'h99; #1;
    check("R7 not ready while disabled", {31'b0, rxReady}, 0);
    @(negedge clk); rxValid = 1'b0;
    wr(8'h0C, 32'h1);
    rd(8'h0C, "R5 rx enable reads 1", 1);
    for (int i = 0; i < 8; i++) rxOffer(8'h10 + 8'(i));
    @(negedge clk); rxValid = 1'b1; rxData = 8'hEE; #1;
    check("R11 rx full after eight", {31'b0, rxReady}, 0);
    waitCycles(2);
    rxValid = 1'b0;
    for (int i = 0; i < 8; i++) rd(8'h04, "R4 R11 pop order", 32'h10 + i);
    rd(8'h04, "R4 empty after drain", 32'h8000_0000);
    rd(8'h04, "R4 empty pop removes nothing", 32'h8000_0000);

    // R8: ignored writes and placeholder reads
    rxOffer(8'h5A);
    rxOffer(8'hC3);
    wr(8'h04, 32'h77);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0);
    rd(8'h10, "R8 ie reads 0", 0);
    rd(8'h14, "R8 ip reads 0", 0);
    rd(8'h18, "R8 div reads 1", 1);
    rd(8'h04, "R8 rx write ignored first", 32'h5A);
    rd(8'h04, "R8 rx write ignored second", 32'hC3);
    rd(8'h04, "R8 rx empty", 32'h8000_0000);

    // R9 R10: error codes and no side effects
    access(1'b0, 8'h02, 0, d, e);
    check("R9 misaligned code", {30'b0, e}, 1);
    check("R9 misaligned data", d, 0);
    access(1'b1, 8'h09, 32'h0, d, e);
    check("R9 misaligned write code", {30'b0, e}, 1);
    rd(8'h08, "R9 enable untouched", 1);
    access(1'b1, 8'h01, 32'h42, d, e);
    access(1'b0, 8'h1B, 0, d, e);
    check("R9 top misaligned", {30'b0, e}, 1);
    access(1'b0, 8'h1C, 0, d, e);
    check("R10 fault code", {30'b0, e}, 2);
    check("R10 fault data", d, 0);
    access(1'b1, 8'hFC, 32'h1, d, e);
    check("R10 fault write", {30'b0, e}, 2);
    access(1'b0, 8'h18, 0, d, e);
    check("R8 div ok code", {30'b0, e}, 0);
    waitCycles(4);
    check("R9 R10 no stray tx", txExpect.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule